// File: doc/BRIEF.md
# D-Channel Byte Assembler and Disassembler

This block sits on a framed, time-slotted serial line that gives two signalling bits to the D channel in every frame. On the receive side it picks those two bits out of each frame, gathers eight of them across four consecutive frames, and delivers the finished byte in a holding register together with a single-cycle valid strobe. On the transmit side it takes one byte from a holding register at the start of each four-frame group and puts two of its bits on the line in each of the four frames.

A bit-order input chooses between two conventions for the whole group. In least-significant-first order (used for HDLC traffic) the earliest bit on the line is byte bit 0. In most-significant-first order (raw data) the earliest bit on the line is byte bit 7. Both directions follow the same convention. A frame marker restarts the count of D slots inside a frame, and a slot strobe marks the clock cycles in which a D bit is on the line.

Top module: `dch_byte_engine`

## Requirements
- R1: With `mode_lsb_first`=1 latched for a group, the first received D bit lands in `rx_data[0]` and the eighth in `rx_data[7]`.
- R2: With `mode_lsb_first`=0 latched for a group, the first received D bit lands in `rx_data[7]` and the eighth in `rx_data[0]`.
- R3: On transmit, a byte loaded through `tx_data`/`tx_load` appears on `line_tx` during the eight taken slots of the next group, in the same bit order that R1/R2 give for the mode in force.
- R4: `rx_valid` is high for exactly one cycle, the cycle after the clock edge that samples the eighth bit of a group, and `rx_data` holds the new byte from that cycle onward.
- R5: `line_tx` is 1 in every cycle that is not a taken D slot, and a group that starts with no byte pending sends eight 1 bits.
- R6: If a byte completes while the previous byte is still unread, `rx_overrun` goes to 1 and `rx_data` takes the newer byte. A pulse on `rx_read` clears `rx_overrun`.
- R7: The bit order is sampled from `mode_lsb_first` at the first slot of a group. A change during the group has no effect until the next group starts.
- R8: Only the first two slot strobes after a frame marker are taken. Further strobes in that frame leave the receive byte unchanged and see `line_tx`=1.
- R9: If `rx_read` arrives in the same cycle that a new byte completes, `rx_overrun` stays 0 and the new byte is delivered normally.
- R10: If `tx_load` arrives in the same cycle as the first slot of a group, the byte already pending is sent. The newly loaded byte stays pending (`tx_ready`=0) and is sent in the following group.
- R11: A low `rst_n` sampled at a clock edge clears the group position, the shift registers, the pending transmit byte and the flags. After reset, `tx_ready`=1, `rx_valid`=0 and `rx_overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_lsb_first | input | 1 | 1: least significant bit first; 0: most significant bit first |
| frame_sync | input | 1 | Frame marker; restarts the in-frame slot count |
| d_slot | input | 1 | High in a cycle that carries a D bit |
| line_rx | input | 1 | Serial receive data |
| line_tx | output | 1 | Serial transmit data, 1 when idle |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Writes `tx_data` into the transmit holding register |
| tx_ready | output | 1 | No transmit byte pending |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_read | input | 1 | Acknowledges the received byte |
| rx_overrun | output | 1 | A byte was overwritten before it was read |

## Verification
Two pairs of events can land in the same clock cycle. One pair is the receive completion and the host acknowledge. The bench raises `rx_read` in exactly the cycle of the eighth slot while an older byte is still unread, and requires the overrun flag to stay clear while the new byte is still delivered. The other pair is a transmit write and the group-start byte take. The bench writes a second byte during the first slot of a group, then checks the serialised bits to confirm that the older byte went out, that the ready flag stays low, and that the newer byte appears in the next group.

// File: rtl/dch_pkg.sv
package dch_pkg;
   typedef enum logic {
      ORD_MSB_FIRST = 1'b0,
      ORD_LSB_FIRST = 1'b1
   } bit_order_t;
endpackage

// File: rtl/dch_slot_timer.sv
module dch_slot_timer
   import dch_pkg::*;
#(
   parameter int SLOTS_PER_FRAME = 2,
   parameter int FRAMES_PER_BYTE = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_sync,
   input  logic       d_slot,
   input  logic       mode_lsb_first,
   output logic       take,
   output logic       grp_start,
   output logic       grp_end,
   output bit_order_t order_eff
);
   localparam int BYTE_W = SLOTS_PER_FRAME * FRAMES_PER_BYTE;
   localparam int SLOT_W = $clog2(SLOTS_PER_FRAME + 1);
   localparam int BIT_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);
   localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(SLOTS_PER_FRAME);

   generate
      if (SLOTS_PER_FRAME < 1) begin : g_bad_slots
         $error("SLOTS_PER_FRAME must be at least 1");
      end
      if (FRAMES_PER_BYTE < 1) begin : g_bad_frames
         $error("FRAMES_PER_BYTE must be at least 1");
      end
      if (BYTE_W < 2) begin : g_bad_width
         $error("a byte needs at least two bits");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_cnt;
   logic [BIT_W-1:0]  bit_pos;
   bit_order_t        grp_order;
   logic              room;

   assign room      = frame_sync || (slot_cnt < SLOT_LIM);
   assign take      = d_slot && room;
   assign grp_start = take && (bit_pos == '0);
   assign grp_end   = take && (bit_pos == LAST_BIT);
   assign order_eff = (bit_pos == '0) ? bit_order_t'(mode_lsb_first) : grp_order;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_cnt <= '0;
      end else if (frame_sync) begin
         slot_cnt <= d_slot ? SLOT_W'(1) : '0;
      end else if (take) begin
         slot_cnt <= slot_cnt + SLOT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_pos <= '0;
      end else if (take) begin
         bit_pos <= (bit_pos == LAST_BIT) ? '0 : bit_pos + BIT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_order <= ORD_MSB_FIRST;
      end else if (grp_start) begin
         grp_order <= bit_order_t'(mode_lsb_first);
      end
   end

   // R8: never more slots counted than a frame holds
   a_r8_slot_limit: assert property (@(posedge clk) disable iff (!rst_n)
      slot_cnt <= SLOT_LIM);

   // R7: the latched order stays put while a group is in progress
   a_r7_order_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_pos != '0) |=> $stable(grp_order));
endmodule

// File: rtl/dch_rx_assembler.sv
module dch_rx_assembler
   import dch_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              grp_end,
   input  bit_order_t        order_eff,
   input  logic              line_rx,
   input  logic              rx_read,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_overrun
);
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] shreg_nxt;
   logic              rx_full;

   always_comb begin
      if (order_eff == ORD_LSB_FIRST) begin
         shreg_nxt = {line_rx, shreg[BYTE_W-1:1]};
      end else begin
         shreg_nxt = {shreg[BYTE_W-2:0], line_rx};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (take) begin
         shreg <= shreg_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         rx_full    <= 1'b0;
         rx_overrun <= 1'b0;
      end else begin
         rx_valid <= grp_end;
         if (grp_end) begin
            rx_data <= shreg_nxt;
         end
         if (grp_end) begin
            rx_full <= 1'b1;
         end else if (rx_read) begin
            rx_full <= 1'b0;
         end
         if (grp_end && rx_full && !rx_read) begin
            rx_overrun <= 1'b1;
         end else if (rx_read) begin
            rx_overrun <= 1'b0;
         end
      end
   end

   // R4: the strobe never lasts two cycles
   a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6: overrun only rises when an unread byte was held
   a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> $past(rx_full));
endmodule

// File: rtl/dch_tx_disassembler.sv
module dch_tx_disassembler
   import dch_pkg::*;
#(
   parameter int   BYTE_W   = 8,
   parameter logic IDLE_BIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              grp_start,
   input  bit_order_t        order_eff,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_load,
   output logic              tx_ready,
   output logic              line_tx
);
   localparam logic [BYTE_W-1:0] IDLE_WORD = {BYTE_W{IDLE_BIT}};

   logic [BYTE_W-1:0] hold;
   logic              pending;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] word;
   logic              cur_bit;

   assign word     = grp_start ? (pending ? hold : IDLE_WORD) : shreg;
   assign cur_bit  = (order_eff == ORD_LSB_FIRST) ? word[0] : word[BYTE_W-1];
   assign line_tx  = take ? cur_bit : IDLE_BIT;
   assign tx_ready = !pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold    <= '0;
         pending <= 1'b0;
      end else if (tx_load) begin
         hold    <= tx_data;
         pending <= 1'b1;
      end else if (grp_start) begin
         pending <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= IDLE_WORD;
      end else if (take) begin
         if (order_eff == ORD_LSB_FIRST) begin
            shreg <= {IDLE_BIT, word[BYTE_W-1:1]};
         end else begin
            shreg <= {word[BYTE_W-2:0], IDLE_BIT};
         end
      end
   end

   // R10: a write always leaves a byte pending afterwards
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_ready);
endmodule

// File: rtl/dch_byte_engine.sv
module dch_byte_engine
   import dch_pkg::*;
#(
   parameter int SLOTS_PER_FRAME = 2,
   parameter int FRAMES_PER_BYTE = 4,
   localparam int BYTE_W = SLOTS_PER_FRAME * FRAMES_PER_BYTE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_lsb_first,
   input  logic              frame_sync,
   input  logic              d_slot,
   input  logic              line_rx,
   output logic              line_tx,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_load,
   output logic              tx_ready,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_read,
   output logic              rx_overrun
);
   logic       take;
   logic       grp_start;
   logic       grp_end;
   bit_order_t order_eff;

   dch_slot_timer #(
      .SLOTS_PER_FRAME(SLOTS_PER_FRAME),
      .FRAMES_PER_BYTE(FRAMES_PER_BYTE)
   ) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_sync    (frame_sync),
      .d_slot        (d_slot),
      .mode_lsb_first(mode_lsb_first),
      .take          (take),
      .grp_start     (grp_start),
      .grp_end       (grp_end),
      .order_eff     (order_eff)
   );

   dch_rx_assembler #(.BYTE_W(BYTE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .grp_end   (grp_end),
      .order_eff (order_eff),
      .line_rx   (line_rx),
      .rx_read   (rx_read),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .rx_overrun(rx_overrun)
   );

   dch_tx_disassembler #(.BYTE_W(BYTE_W), .IDLE_BIT(1'b1)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .grp_start(grp_start),
      .order_eff(order_eff),
      .tx_data  (tx_data),
      .tx_load  (tx_load),
      .tx_ready (tx_ready),
      .line_tx  (line_tx)
   );

   // R5: outside D slots the line rests high
   a_r5_idle_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !d_slot |-> line_tx);

   // R11: right after reset nothing is pending or flagged
   a_r11_reset_clean: assert property (@(posedge clk)
      !rst_n |=> (tx_ready && !rx_valid && !rx_overrun));
endmodule

// File: tb/tb_dch_byte_engine.sv
module tb_dch_byte_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_lsb_first = 1'b1;
   logic       frame_sync = 1'b0;
   logic       d_slot = 1'b0;
   logic       line_rx = 1'b0;
   logic       line_tx;
   logic [7:0] tx_data = '0;
   logic       tx_load = 1'b0;
   logic       tx_ready;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_read = 1'b0;
   logic       rx_overrun;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dch_byte_engine dut (
      .clk(clk), .rst_n(rst_n), .mode_lsb_first(mode_lsb_first),
      .frame_sync(frame_sync), .d_slot(d_slot), .line_rx(line_rx),
      .line_tx(line_tx), .tx_data(tx_data), .tx_load(tx_load),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_read(rx_read), .rx_overrun(rx_overrun)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic slot_cycle(input logic b, output logic seen);
      d_slot  = 1'b1;
      line_rx = b;
      #1 seen = line_tx;
      @(negedge clk);
      d_slot  = 1'b0;
      tx_load = 1'b0;
      rx_read = 1'b0;
   endtask

   task automatic load_tx(input logic [7:0] v);
      tx_data = v;
      tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
   endtask

   task automatic do_read();
      rx_read = 1'b1;
      @(negedge clk);
      rx_read = 1'b0;
   endtask

   // one four-frame group; lsb_line gives the order in which rxb is put on the line
   task automatic group(input logic [7:0] rxb, input logic lsb_line, input int flip_at,
                        input bit read_last, input bit extra, input bit load_first,
                        input logic [7:0] load_val, output logic [7:0] txw);
      logic t;
      logic [7:0] tw = '0;
      for (int f = 0; f < 4; f++) begin
         if (f == flip_at) mode_lsb_first = ~mode_lsb_first;
         frame_sync = 1'b1;
         @(negedge clk);
         frame_sync = 1'b0;
         @(negedge clk);
         for (int s = 0; s < 2; s++) begin
            int i = f * 2 + s;
            logic b = lsb_line ? rxb[i] : rxb[7 - i];
            if (read_last && i == 7) rx_read = 1'b1;
            if (load_first && i == 0) begin
               tx_data = load_val;
               tx_load = 1'b1;
            end
            slot_cycle(b, t);
            if (lsb_line) tw[i] = t; else tw[7 - i] = t;
         end
         if (extra && f == 1) begin
            slot_cycle(~rxb[0], t);
            check(t == 1'b1, "R8 extra slot line_tx", t, 1);
         end
      end
      txw = tw;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] txw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_ready == 1'b1, "R11 reset tx_ready", tx_ready, 1);
      check(rx_valid == 1'b0, "R11 reset rx_valid", rx_valid, 0);
      check(rx_overrun == 1'b0, "R11 reset rx_overrun", rx_overrun, 0);
      check(line_tx == 1'b1, "R5 reset line idle", line_tx, 1);

      // sweep every byte in both orders: R1 R2 R3 R4
      for (int m = 0; m < 2; m++) begin
         mode_lsb_first = m[0];
         for (int v = 0; v < 256; v++) begin
            logic [7:0] rv = v[7:0];
            logic [7:0] tv = rv ^ 8'hA5;
            load_tx(tv);
            group(rv, m[0], -1, 0, 0, 0, 8'h00, txw);
            check(rx_valid == 1'b1, "R4 valid strobe", rx_valid, 1);
            check(rx_data == rv, m ? "R1 lsb-first receive" : "R2 msb-first receive", rx_data, rv);
            check(txw == tv, "R3 transmit order", txw, tv);
            do_read();
            check(rx_valid == 1'b0, "R4 strobe one cycle", rx_valid, 0);
         end
      end

      // R5: nothing pending sends all ones
      mode_lsb_first = 1'b1;
      check(tx_ready == 1'b1, "R5 nothing pending", tx_ready, 1);
      group(8'h5A, 1, -1, 0, 0, 0, 8'h00, txw);
      check(txw == 8'hFF, "R5 idle group", txw, 8'hFF);
      do_read();

      // R6: overrun and overwrite
      group(8'h3C, 1, -1, 0, 0, 0, 8'h00, txw);
      group(8'hC3, 1, -1, 0, 0, 0, 8'h00, txw);
      check(rx_overrun == 1'b1, "R6 overrun set", rx_overrun, 1);
      check(rx_data == 8'hC3, "R6 newer byte kept", rx_data, 8'hC3);
      do_read();
      check(rx_overrun == 1'b0, "R6 overrun cleared by read", rx_overrun, 0);

      // R9: read in the completion cycle
      group(8'h11, 1, -1, 0, 0, 0, 8'h00, txw);
      group(8'h22, 1, -1, 1, 0, 0, 8'h00, txw);
      check(rx_overrun == 1'b0, "R9 no overrun on same-cycle read", rx_overrun, 0);
      check(rx_valid == 1'b1, "R9 valid strobe", rx_valid, 1);
      check(rx_data == 8'h22, "R9 byte delivered", rx_data, 8'h22);
      do_read();

      // R7: mode flip mid-group ignored until next group
      mode_lsb_first = 1'b1;
      load_tx(8'h96);
      group(8'h5B, 1, 2, 0, 0, 0, 8'h00, txw);
      check(rx_data == 8'h5B, "R7 receive keeps group order", rx_data, 8'h5B);
      check(txw == 8'h96, "R7 transmit keeps group order", txw, 8'h96);
      do_read();
      load_tx(8'h2D);
      group(8'h5B, 0, -1, 0, 0, 0, 8'h00, txw);
      check(rx_data == 8'h5B, "R7 new order next group", rx_data, 8'h5B);
      check(txw == 8'h2D, "R7 new tx order next group", txw, 8'h2D);
      do_read();

      // R8: third strobe in a frame ignored
      group(8'h77, 0, -1, 0, 1, 0, 8'h00, txw);
      check(rx_data == 8'h77, "R8 byte unaffected by extra slot", rx_data, 8'h77);
      do_read();

      // R10: write collides with group-start take
      mode_lsb_first = 1'b1;
      load_tx(8'hA1);
      group(8'h01, 1, -1, 0, 0, 1, 8'hB2, txw);
      check(txw == 8'hA1, "R10 older byte sent", txw, 8'hA1);
      check(tx_ready == 1'b0, "R10 newer byte pending", tx_ready, 0);
      do_read();
      group(8'h02, 1, -1, 0, 0, 0, 8'h00, txw);
      check(txw == 8'hB2, "R10 newer byte sent next", txw, 8'hB2);
      check(tx_ready == 1'b1, "R10 ready after send", tx_ready, 1);
      do_read();

      // R11: reset in mid-group
      load_tx(8'hC7);
      begin
         logic t;
         frame_sync = 1'b1;
         @(negedge clk);
         frame_sync = 1'b0;
         slot_cycle(1'b1, t);
         slot_cycle(1'b0, t);
         slot_cycle(1'b1, t);
      end
      load_tx(8'h44);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_ready == 1'b1, "R11 mid-group reset tx_ready", tx_ready, 1);
      check(rx_overrun == 1'b0, "R11 mid-group reset overrun", rx_overrun, 0);
      group(8'hE8, 1, -1, 0, 0, 0, 8'h00, txw);
      check(rx_data == 8'hE8, "R11 fresh group after reset", rx_data, 8'hE8);
      check(txw == 8'hFF, "R11 pending byte dropped", txw, 8'hFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule